// File: doc/BRIEF.md
# Safety-Aware Memory Commit Gate

This block sits beside the head of the reorder buffer. It decides, in the same cycle, whether the oldest memory operation may commit while keeping sequential consistency. A memory access counts as safe when it cannot be seen or changed by another thread. There are two sources for that: the compiler marks the instruction at decode, and address translation marks the page. Ordering is enforced only for unsafe accesses. Safe loads therefore commit even when stores are still pending. Unsafe loads wait only for the ordered (first-in first-out) store buffer to drain.

For stores, the gate also chooses the destination. Safe stores go to the unordered store buffer and unsafe stores go to the ordered one. A store commits only when the chosen buffer has room. A store also waits while a store to the same address sits in the other buffer, unless the translation-time safe bit is set.

The decision is purely combinational from the head entry and the buffer flags. It has no lookahead, and at most one operation commits per cycle. A head that is held back also holds back every younger operation, because nothing behind it is looked at.

Top module: `mem_commit_gate`

## Requirements
- R1: `head_safe` is 1 exactly when `head_static_safe` or `head_dyn_safe` is 1, and it does not depend on the op kind or on any buffer flag.
- R2: A valid load with `head_safe`=1 gets `commit_ok`=1 for every combination of `ord_empty`, `unord_empty`, `ord_has_space`, `unord_has_space` and `xbuf_conflict`.
- R3: A valid unsafe load with `ord_empty`=1 gets `commit_ok`=1 even when `unord_empty`=0.
- R4: A valid unsafe load with `ord_empty`=0 gets `commit_ok`=0, whatever the state of the unordered buffer.
- R5: For a valid store, `route_unordered` is 1 (unordered buffer) when the store is safe and 0 (ordered buffer) when it is unsafe. For loads and for an invalid head, `route_unordered` is 0.
- R6: A valid store with no conflict gets `commit_ok`=1 exactly when the selected buffer reports space: `unord_has_space` for a safe store, `ord_has_space` for an unsafe one.
- R7: A valid store with `xbuf_conflict`=1 gets `commit_ok`=0 when `head_dyn_safe`=0. When `head_dyn_safe`=1 the conflict has no effect and only R6 applies.
- R8: With `head_valid`=0, `commit_ok` is 0 for every other input value.
- R9: A load's commit decision does not depend on `xbuf_conflict`, `ord_has_space` or `unord_has_space`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| head_valid | input | 1 | Oldest reorder-buffer entry is a memory op that is ready to commit |
| head_is_store | input | 1 | 1 = store, 0 = load |
| head_static_safe | input | 1 | Compiler-supplied safe mark, set at decode |
| head_dyn_safe | input | 1 | Page-level safe mark, set at address translation |
| ord_empty | input | 1 | Ordered store buffer holds no stores |
| ord_has_space | input | 1 | Ordered store buffer can accept one store |
| unord_empty | input | 1 | Unordered store buffer holds no stores |
| unord_has_space | input | 1 | Unordered store buffer can accept one store |
| xbuf_conflict | input | 1 | A same-address store is pending in the buffer this store is not routed to |
| commit_ok | output | 1 | Head memory op may commit this cycle |
| route_unordered | output | 1 | For a committing store: 1 = unordered buffer, 0 = ordered buffer |
| head_safe | output | 1 | Combined safe classification of the head |

## Verification
The assertions assume that the buffer flags agree with each other: an empty buffer always reports space. The checks on the head also apply only while `head_valid` is high. The bench sweeps every input combination but skips those where an empty buffer would claim to be full, so the assumption checks never see an impossible pair. Each directed scenario then drives one class of head op against chosen buffer states. Its expected result comes from a rule table in the bench that is separate from the design.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_kind_e;

  typedef enum logic {
    DEST_ORDERED   = 1'b0,
    DEST_UNORDERED = 1'b1
  } sb_dest_e;

  // Either mark is enough: both classifiers are conservative.
  function automatic logic access_is_safe(input logic static_mark,
                                          input logic dyn_mark);
    return static_mark | dyn_mark;
  endfunction

  // A pending same-address store in the other buffer blocks a store
  // unless the page-level mark exempts it.
  function automatic logic conflict_blocks(input logic conflict,
                                           input logic dyn_mark,
                                           input bit   exempt_dyn);
    return conflict && !(exempt_dyn && dyn_mark);
  endfunction

endpackage

// File: rtl/cg_safety_class.sv
module cg_safety_class
  import mcg_pkg::*;
(
  input  logic static_mark,
  input  logic dyn_mark,
  output logic is_safe
);

  assign is_safe = access_is_safe(static_mark, dyn_mark);

endmodule

// File: rtl/cg_load_gate.sv
module cg_load_gate (
  input  logic load_at_head,
  input  logic is_safe,
  input  logic ord_empty,
  output logic load_go
);

  logic order_wait;
  assign order_wait = !is_safe && !ord_empty;
  assign load_go    = load_at_head && !order_wait;

  always_comb begin
    if (load_at_head && is_safe)
      p_safe_load_free_r2: assert (load_go)
        else $error("safe load held back");
    if (load_at_head && !is_safe && !ord_empty)
      p_unsafe_load_waits_r4: assert (!load_go)
        else $error("unsafe load passed a pending ordered store");
  end

endmodule

// File: rtl/cg_store_gate.sv
module cg_store_gate
  import mcg_pkg::*;
#(
  parameter bit EXEMPT_DYN = 1'b1
) (
  input  logic     store_at_head,
  input  logic     is_safe,
  input  logic     dyn_mark,
  input  logic     ord_has_space,
  input  logic     unord_has_space,
  input  logic     xbuf_conflict,
  output logic     store_go,
  output sb_dest_e dest
);

  logic dest_space;
  logic blocked;

  assign dest       = is_safe ? DEST_UNORDERED : DEST_ORDERED;
  assign dest_space = (dest == DEST_UNORDERED) ? unord_has_space : ord_has_space;

  generate
    if (EXEMPT_DYN) begin : g_exempt
      assign blocked = conflict_blocks(xbuf_conflict, dyn_mark, 1'b1);
    end else begin : g_strict
      assign blocked = xbuf_conflict;
    end
  endgenerate

  assign store_go = store_at_head && dest_space && !blocked;

  always_comb begin
    if (store_at_head && xbuf_conflict && !dyn_mark)
      p_conflict_stall_r7: assert (!store_go)
        else $error("store committed over a cross-buffer conflict");
    if (store_go)
      p_room_in_dest_r6: assert ((dest == DEST_UNORDERED) ? unord_has_space : ord_has_space)
        else $error("store committed into a full buffer");
  end

endmodule

// File: rtl/mem_commit_gate.sv
module mem_commit_gate
  import mcg_pkg::*;
#(
  parameter bit EXEMPT_DYN = 1'b1
) (
  input  logic head_valid,
  input  logic head_is_store,
  input  logic head_static_safe,
  input  logic head_dyn_safe,
  input  logic ord_empty,
  input  logic ord_has_space,
  input  logic unord_empty,
  input  logic unord_has_space,
  input  logic xbuf_conflict,
  output logic commit_ok,
  output logic route_unordered,
  output logic head_safe
);

  op_kind_e kind;
  logic     load_at_head;
  logic     store_at_head;
  logic     load_go;
  logic     store_go;
  sb_dest_e store_dest;

  assign kind          = head_is_store ? OP_STORE : OP_LOAD;
  assign load_at_head  = head_valid && (kind == OP_LOAD);
  assign store_at_head = head_valid && (kind == OP_STORE);

  cg_safety_class u_class (
    .static_mark (head_static_safe),
    .dyn_mark    (head_dyn_safe),
    .is_safe     (head_safe)
  );

  cg_load_gate u_load (
    .load_at_head (load_at_head),
    .is_safe      (head_safe),
    .ord_empty    (ord_empty),
    .load_go      (load_go)
  );

  cg_store_gate #(.EXEMPT_DYN(EXEMPT_DYN)) u_store (
    .store_at_head   (store_at_head),
    .is_safe         (head_safe),
    .dyn_mark        (head_dyn_safe),
    .ord_has_space   (ord_has_space),
    .unord_has_space (unord_has_space),
    .xbuf_conflict   (xbuf_conflict),
    .store_go        (store_go),
    .dest            (store_dest)
  );

  // Single head: one commit per cycle at most, and a stall holds everything behind it.
  assign commit_ok       = load_go | store_go;
  assign route_unordered = store_at_head && (store_dest == DEST_UNORDERED);

  always_comb begin
    p_flags_agree_ord: assert (!ord_empty || ord_has_space)
      else $error("ordered buffer empty but full");
    p_flags_agree_unord: assert (!unord_empty || unord_has_space)
      else $error("unordered buffer empty but full");
    p_idle_no_commit_r8: assert (head_valid || !commit_ok)
      else $error("commit with no valid head");
    p_one_path_r9: assert ($countones({load_go, store_go}) <= 1)
      else $error("load and store paths both fired");
    if (load_at_head && !head_safe && ord_empty && !unord_empty)
      p_unsafe_load_skips_unord_r3: assert (commit_ok)
        else $error("unsafe load waited on unordered buffer");
    if (store_at_head)
      p_route_by_safety_r5: assert (route_unordered == (head_static_safe | head_dyn_safe))
        else $error("store routed to wrong buffer");
    if (!store_at_head)
      p_route_quiet_r5: assert (!route_unordered)
        else $error("route asserted for non-store");
    if (head_static_safe || head_dyn_safe)
      p_safe_class_r1: assert (head_safe)
        else $error("safe mark lost");
  end

endmodule

// File: tb/test_mem_commit_gate.sv
module test_mem_commit_gate;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic v, st, ss, ds, oe, os, ue, us, cf;
  logic commit_ok, route_unordered, head_safe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  mem_commit_gate i_mem_commit_gate (
    .head_valid       (v),
    .head_is_store    (st),
    .head_static_safe (ss),
    .head_dyn_safe    (ds),
    .ord_empty        (oe),
    .ord_has_space    (os),
    .unord_empty      (ue),
    .unord_has_space  (us),
    .xbuf_conflict    (cf),
    .commit_ok        (commit_ok),
    .route_unordered  (route_unordered),
    .head_safe        (head_safe)
  );

  // Rule table, written from the requirements.
  function automatic logic want_commit(logic a_v, logic a_st, logic a_ss, logic a_ds,
                                       logic a_oe, logic a_os, logic a_us, logic a_cf);
    logic saf;
    saf = (a_ss == 1'b1) || (a_ds == 1'b1);
    if (!a_v) return 1'b0;                          // R8
    if (!a_st) begin
      if (saf) return 1'b1;                         // R2
      return a_oe;                                  // R3/R4
    end
    if (a_cf && !a_ds) return 1'b0;                 // R7
    if (saf) return a_us;                           // R6
    return a_os;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (v=%0b st=%0b ss=%0b ds=%0b oe=%0b os=%0b ue=%0b us=%0b cf=%0b)",
               req, what, act, exp, v, st, ss, ds, oe, os, ue, us, cf);
    end
  endtask

  task automatic apply(input logic a_v, input logic a_st, input logic a_ss, input logic a_ds,
                       input logic a_oe, input logic a_os, input logic a_ue, input logic a_us,
                       input logic a_cf);
    @(negedge clk);
    v = a_v; st = a_st; ss = a_ss; ds = a_ds;
    oe = a_oe; os = a_os; ue = a_ue; us = a_us; cf = a_cf;
    #1;
  endtask

  task automatic t_idle();
    apply(0, 0, 0, 0, 1, 1, 1, 1, 0);
    check("R8", "idle commit", commit_ok, 1'b0);
    check("R5", "idle route", route_unordered, 1'b0);
    apply(0, 1, 1, 1, 1, 1, 1, 1, 0);
    check("R8", "invalid store commit", commit_ok, 1'b0);
  endtask

  task automatic t_classify();
    apply(1, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R1", "static only", head_safe, 1'b1);
    apply(1, 1, 0, 1, 0, 0, 0, 0, 1);
    check("R1", "dynamic only", head_safe, 1'b1);
    apply(1, 0, 0, 0, 1, 1, 1, 1, 0);
    check("R1", "neither", head_safe, 1'b0);
  endtask

  task automatic t_safe_load();
    apply(1, 0, 1, 0, 0, 0, 0, 0, 1);
    check("R2", "safe load both busy", commit_ok, 1'b1);
    apply(1, 0, 0, 1, 0, 1, 1, 1, 0);
    check("R2", "dyn-safe load ordered busy", commit_ok, 1'b1);
  endtask

  task automatic t_unsafe_load();
    apply(1, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R3", "unsafe load unord busy", commit_ok, 1'b1);
    apply(1, 0, 0, 0, 0, 1, 1, 1, 0);
    check("R4", "unsafe load ord pending", commit_ok, 1'b0);
    apply(1, 0, 0, 0, 1, 1, 1, 1, 1);
    check("R9", "unsafe load with conflict flag", commit_ok, 1'b1);
    check("R5", "load route", route_unordered, 1'b0);
  endtask

  task automatic t_store();
    apply(1, 1, 1, 0, 0, 0, 0, 1, 0);
    check("R5", "safe store route", route_unordered, 1'b1);
    check("R6", "safe store unord room", commit_ok, 1'b1);
    apply(1, 1, 1, 0, 1, 1, 0, 0, 0);
    check("R6", "safe store unord full", commit_ok, 1'b0);
    apply(1, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R5", "unsafe store route", route_unordered, 1'b0);
    check("R6", "unsafe store ord room", commit_ok, 1'b1);
    apply(1, 1, 0, 0, 0, 0, 1, 1, 0);
    check("R6", "unsafe store ord full", commit_ok, 1'b0);
  endtask

  task automatic t_conflict();
    apply(1, 1, 1, 0, 1, 1, 1, 1, 1);
    check("R7", "static-safe store conflict", commit_ok, 1'b0);
    apply(1, 1, 0, 0, 1, 1, 1, 1, 1);
    check("R7", "unsafe store conflict", commit_ok, 1'b0);
    apply(1, 1, 0, 1, 1, 1, 1, 1, 1);
    check("R7", "dyn-safe store ignores conflict", commit_ok, 1'b1);
    apply(1, 1, 0, 1, 0, 1, 0, 0, 1);
    check("R7", "dyn-safe store conflict, unord full", commit_ok, 1'b0);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 512; k++) begin
      logic [8:0] b;
      b = k[8:0];
      if ((b[4] && !b[5]) || (b[6] && !b[7])) continue;  // empty implies room
      apply(b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7], b[8]);
      check("R2", "sweep commit (R3 R4 R6 R7 R8 R9)", commit_ok,
            want_commit(b[0], b[1], b[2], b[3], b[4], b[5], b[7], b[8]));
      check("R1", "sweep safe", head_safe, b[2] | b[3]);
      check("R5", "sweep route", route_unordered, b[0] & b[1] & (b[2] | b[3]));
    end
  endtask

  initial begin
    v = 0; st = 0; ss = 0; ds = 0; oe = 1; os = 1; ue = 1; us = 1; cf = 0;
    t_idle();
    t_classify();
    t_safe_load();
    t_unsafe_load();
    t_store();
    t_conflict();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule